// File: doc/BRIEF.md
# Pin Event Detector with Grouped Interrupt Lines

This block watches every pin of a 54-pin general-purpose port and records, per pin, the events that software has armed. Six kinds of event can be armed independently for each pin. Four are sampled on the system clock from the already-synchronised pin level: a rising edge, a falling edge, a high level and a low level. Two are taken straight from the raw pin: a rising edge and a falling edge. These two are caught even when the pulse is shorter than a clock period. An armed event sets a sticky status bit. Software clears that bit by writing a one to it.

The status vector drives three interrupt lines. Each line is the OR of a fixed, contiguous range of pins. The middle range straddles the 32-bit register boundary, so one interrupt can be caused by bits in both status words. Software reaches the enable and status words through a simple 32-bit register bus with a write strobe and a combinational read port. Pin p lives in word p/32 at bit p%32 of every per-pin register.

Top module: `gpev_top`

## Requirements
- R1: After reset, all six enable words, both status words and all three interrupt lines are zero.
- R2: With the synchronous rising enable set (word 0 at 0x4C, word 1 at 0x50), the pin's status bit sets at the first clock where the synchronised level is 1 and was 0 on the previous clock. A level that stays high does not set it again after a clear.
- R3: With the synchronous falling enable set (0x58 / 0x5C), a 1-to-0 change of the synchronised level sets the status bit. A rising edge does not.
- R4: A pin with both the rising and falling enables set records both of its edges.
- R5: With the high-level enable set (0x64 / 0x68), the status bit is set on every clock while the level is 1. A clear has no lasting effect until the level has returned to 0.
- R6: With the low-level enable set (0x70 / 0x74), the status bit is set on every clock while the level is 0.
- R7: With the raw-rising enable set (0x7C / 0x80) or the raw-falling enable set (0x88 / 0x8C), the matching edge of the raw pin input sets the status bit within four clocks. This holds even for a pulse shorter than one clock. Edges of a kind whose enable is clear set nothing.
- R8: The status words are at 0x40 (pins 0..31) and 0x44 (pins 32..53). Writing a 1 to a bit clears it, and bits written as 0 keep their value.
- R9: With all enables of a pin clear, no activity on that pin sets its status bit. A bit set earlier stays set after its enable is turned off, until it is written with a 1.
- R10: When a clear and a new event hit the same status bit in the same clock, the bit ends up set.
- R11: Line irq[0] is the OR of the status bits of pins 0..27, irq[1] of pins 28..45 and irq[2] of pins 46..53. All three are combinational from the status register.
- R12: Every enable word reads back as written. Bits above pin 53 in word 1 read as 0. Enable words change only on a bus write to their address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 8 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr, zero for unmapped addresses |
| pin_sync | input | 54 | Pin levels already synchronised to clk |
| pin_raw | input | 54 | Unsynchronised pin inputs for the raw-edge detectors |
| irq | output | 3 | Grouped interrupt lines |

## Verification
The bench attacks the exact cycle of edge detection. A design that compares against the wrong previous level would either miss the edge or set the bit again while the level holds. Pins 30 and 40 sit on either side of the word boundary and both belong to irq[1]; a wrong mask would raise irq[0] or irq[2] instead. The bench writes a clear in the same cycle as a new rising edge, so a design that gives the clear priority loses the event. It also arms a high level and clears it while the level holds, which exposes a design that latches levels only once. Sub-cycle pulses on the raw inputs check that the asynchronous capture does not rely on the clock seeing the pulse. Writes with zero bits show whether the clear works as a plain store instead of write-one-to-clear.

// File: rtl/gpev_pkg.sv
package gpev_pkg;

    // Event kinds, index into the packed enable vector
    localparam int K_RISE  = 0;
    localparam int K_FALL  = 1;
    localparam int K_HIGH  = 2;
    localparam int K_LOW   = 3;
    localparam int K_ARISE = 4;
    localparam int K_AFALL = 5;
    localparam int NKIND   = 6;

    // Address map: status words, then six enable kinds with a 12-byte stride
    localparam int STATUS_BASE = 'h40;
    localparam int EN_BASE     = 'h4C;
    localparam int KIND_STRIDE = 'h0C;
    localparam int WORD_STRIDE = 4;

    function automatic int en_addr(int kind, int word);
        return EN_BASE + kind * KIND_STRIDE + word * WORD_STRIDE;
    endfunction

    function automatic int st_addr(int word);
        return STATUS_BASE + word * WORD_STRIDE;
    endfunction

endpackage

// File: rtl/gpev_regs.sv
module gpev_regs
    import gpev_pkg::*;
#(
    parameter int NPINS = 54,
    parameter int DW    = 32,
    parameter int AW    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_we,
    input  logic [AW-1:0]           bus_addr,
    input  logic [DW-1:0]           bus_wdata,
    output logic [DW-1:0]           bus_rdata,
    input  logic [NPINS-1:0]        status,
    output logic [NKIND*NPINS-1:0]  en_vec,
    output logic [NPINS-1:0]        clr_vec
);
    localparam int NWORD = (NPINS + DW - 1) / DW;
    localparam int NPAD  = NWORD * DW;
    localparam logic [NPAD-1:0] VALID = {NPAD{1'b1}} >> (NPAD - NPINS);

    logic [NKIND-1:0][NPAD-1:0] en_q;
    logic [NKIND-1:0][NWORD-1:0] hit_en;
    logic [NWORD-1:0]           hit_st;
    logic [NPAD-1:0]            st_pad;

    assign st_pad = NPAD'(status);

    // Address decode for writes
    always_comb begin
        for (int k = 0; k < NKIND; k++) begin
            for (int w = 0; w < NWORD; w++) begin
                hit_en[k][w] = bus_we && (bus_addr == AW'(en_addr(k, w)));
            end
        end
        for (int w = 0; w < NWORD; w++) begin
            hit_st[w] = bus_we && (bus_addr == AW'(st_addr(w)));
        end
    end

    // Enable storage, unused pad bits are forced to zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            for (int k = 0; k < NKIND; k++) begin
                for (int w = 0; w < NWORD; w++) begin
                    if (hit_en[k][w]) begin
                        en_q[k][w*DW +: DW] <= bus_wdata & VALID[w*DW +: DW];
                    end
                end
            end
        end
    end

    // Per-kind enable vectors to the detectors
    for (genvar k = 0; k < NKIND; k++) begin : g_en_out
        assign en_vec[k*NPINS +: NPINS] = en_q[k][NPINS-1:0];
    end

    // Write-one-to-clear strobes per pin
    for (genvar p = 0; p < NPINS; p++) begin : g_clr
        localparam int WI = p / DW;
        localparam int BI = p % DW;
        assign clr_vec[p] = hit_st[WI] & bus_wdata[BI];
    end

    // Combinational read port
    always_comb begin
        bus_rdata = '0;
        for (int w = 0; w < NWORD; w++) begin
            if (bus_addr == AW'(st_addr(w))) begin
                bus_rdata = st_pad[w*DW +: DW];
            end
            for (int k = 0; k < NKIND; k++) begin
                if (bus_addr == AW'(en_addr(k, w))) begin
                    bus_rdata = en_q[k][w*DW +: DW];
                end
            end
        end
    end

endmodule

// File: rtl/gpev_detect.sv
module gpev_detect
    import gpev_pkg::*;
#(
    parameter int NPINS = 54
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPINS-1:0]        pin_sync,
    input  logic [NPINS-1:0]        pin_raw,
    input  logic [NKIND*NPINS-1:0]  en_vec,
    output logic [NPINS-1:0]        evt
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic lvl_prev;
        logic tog_r, tog_f;
        logic [2:0] sr_r, sr_f;
        logic ev_rise, ev_fall, ev_high, ev_low, ev_ar, ev_af;

        // Previous synchronised level for clocked edge compare
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_prev <= 1'b0;
            else        lvl_prev <= pin_sync[p];
        end

        // Toggle flops clocked by the raw pin itself
        always_ff @(posedge pin_raw[p] or negedge rst_n) begin
            if (!rst_n) tog_r <= 1'b0;
            else        tog_r <= ~tog_r;
        end

        always_ff @(negedge pin_raw[p] or negedge rst_n) begin
            if (!rst_n) tog_f <= 1'b0;
            else        tog_f <= ~tog_f;
        end

        // Bring the toggles into the clock domain, third stage for change detect
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sr_r <= '0;
                sr_f <= '0;
            end else begin
                sr_r <= {sr_r[1:0], tog_r};
                sr_f <= {sr_f[1:0], tog_f};
            end
        end

        assign ev_rise = en_vec[K_RISE*NPINS + p]  &  pin_sync[p] & ~lvl_prev;
        assign ev_fall = en_vec[K_FALL*NPINS + p]  & ~pin_sync[p] &  lvl_prev;
        assign ev_high = en_vec[K_HIGH*NPINS + p]  &  pin_sync[p];
        assign ev_low  = en_vec[K_LOW*NPINS + p]   & ~pin_sync[p];
        assign ev_ar   = en_vec[K_ARISE*NPINS + p] & (sr_r[2] ^ sr_r[1]);
        assign ev_af   = en_vec[K_AFALL*NPINS + p] & (sr_f[2] ^ sr_f[1]);

        assign evt[p] = ev_rise | ev_fall | ev_high | ev_low | ev_ar | ev_af;
    end

endmodule

// File: rtl/gpev_status.sv
module gpev_status #(
    parameter int NPINS = 54
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] evt,
    input  logic [NPINS-1:0] clr_vec,
    output logic [NPINS-1:0] status
);
    // A new event takes priority over a clear of the same bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_vec) | evt;
    end

endmodule

// File: rtl/gpev_irqfold.sv
module gpev_irqfold #(
    parameter int          NPINS  = 54,
    parameter int          NLINES = 3,
    parameter int unsigned LINE_START [NLINES] = '{0, 28, 46}
) (
    input  logic [NPINS-1:0]  status,
    output logic [NLINES-1:0] irq
);
    function automatic logic [NPINS-1:0] line_mask(int j);
        int lo, hi;
        logic [NPINS-1:0] m;
        lo = int'(LINE_START[j]);
        hi = (j == NLINES - 1) ? NPINS : int'(LINE_START[j+1]);
        m  = '0;
        for (int p = 0; p < NPINS; p++) begin
            if (p >= lo && p < hi) m[p] = 1'b1;
        end
        return m;
    endfunction

    for (genvar j = 0; j < NLINES; j++) begin : g_line
        localparam logic [NPINS-1:0] MASK = line_mask(j);
        assign irq[j] = |(status & MASK);
    end

endmodule

// File: rtl/gpev_top.sv
module gpev_top
    import gpev_pkg::*;
#(
    parameter int NPINS  = 54,
    parameter int DW     = 32,
    parameter int AW     = 8,
    parameter int NLINES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NPINS-1:0]  pin_sync,
    input  logic [NPINS-1:0]  pin_raw,
    output logic [NLINES-1:0] irq
);
    logic [NKIND*NPINS-1:0] en_vec;
    logic [NPINS-1:0]       clr_vec;
    logic [NPINS-1:0]       evt;
    logic [NPINS-1:0]       status_q;

    gpev_regs #(.NPINS(NPINS), .DW(DW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .status    (status_q),
        .en_vec    (en_vec),
        .clr_vec   (clr_vec)
    );

    gpev_detect #(.NPINS(NPINS)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_sync (pin_sync),
        .pin_raw  (pin_raw),
        .en_vec   (en_vec),
        .evt      (evt)
    );

    gpev_status #(.NPINS(NPINS)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .clr_vec (clr_vec),
        .status  (status_q)
    );

    gpev_irqfold #(.NPINS(NPINS), .NLINES(NLINES)) u_fold (
        .status (status_q),
        .irq    (irq)
    );

endmodule

// File: rtl/gpev_chk.sv
module gpev_chk #(
    parameter int NPINS  = 54,
    parameter int ENW    = 324,
    parameter int NLINES = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NPINS-1:0]  status,
    input logic [NPINS-1:0]  evt,
    input logic [NPINS-1:0]  clr,
    input logic [ENW-1:0]    en_vec,
    input logic              bus_we,
    input logic [NLINES-1:0] irq
);
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R8
    status_fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ((~status & $past(status) & ~$past(clr)) == '0));

    // R9
    status_rise_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ((status & ~$past(status) & ~$past(evt)) == '0));

    // R10
    event_always_lands_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (($past(evt) & ~status) == '0));

    // R11
    quiet_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> (irq == '0));

    // R12
    enables_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(en_vec));

endmodule

bind gpev_top gpev_chk #(
    .NPINS  (NPINS),
    .ENW    (gpev_pkg::NKIND * NPINS),
    .NLINES (NLINES)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .status (status_q),
    .evt    (evt),
    .clr    (clr_vec),
    .en_vec (en_vec),
    .bus_we (bus_we),
    .irq    (irq)
);

// File: tb/tb_gpev_top.sv
module tb_gpev_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [53:0] pin_sync = '0;
    logic [53:0] pin_raw = '0;
    logic [2:0]  irq;

    int checks = 0;
    int fails  = 0;

    gpev_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_sync  (pin_sync),
        .pin_raw   (pin_raw),
        .irq       (irq)
    );

    always #2 clk = ~clk;

    localparam logic [7:0] A_ST0 = 8'h40, A_ST1 = 8'h44;
    localparam logic [7:0] A_RISE0 = 8'h4C, A_RISE1 = 8'h50;
    localparam logic [7:0] A_FALL0 = 8'h58, A_FALL1 = 8'h5C;
    localparam logic [7:0] A_HIGH0 = 8'h64, A_HIGH1 = 8'h68;
    localparam logic [7:0] A_LOW0 = 8'h70;
    localparam logic [7:0] A_AR0 = 8'h7C, A_AF1 = 8'h8C;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cleanup();
        for (int k = 0; k < 6; k++) begin
            wr(8'(8'h4C + 12*k), 32'h0);
            wr(8'(8'h50 + 12*k), 32'h0);
        end
        pin_sync = '0;
        pin_raw  = '0;
        tick(5);
        wr(A_ST0, 32'hFFFF_FFFF);
        wr(A_ST1, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 'h40; a <= 'h8C; a += 4) begin
            rd(8'(a), v);
            chk(v == 0, "R1 register zero after reset", v, 0);
        end
        chk(irq == 0, "R1 irq after reset", 32'(irq), 0);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        wr(A_RISE1, 32'hFFFF_FFFF);
        rd(A_RISE1, v);
        chk(v == 32'h003F_FFFF, "R12 word1 pad bits zero", v, 32'h003F_FFFF);
        wr(A_HIGH0, 32'hA5A5_5A5A);
        rd(A_HIGH0, v);
        chk(v == 32'hA5A5_5A5A, "R12 word0 readback", v, 32'hA5A5_5A5A);
        wr(A_RISE1, 0);
        wr(A_HIGH0, 0);
        tick();
        wr(A_ST0, 32'hFFFF_FFFF);
        wr(A_ST1, 32'hFFFF_FFFF);
    endtask

    task automatic t_rise();
        logic [31:0] v;
        wr(A_RISE0, 32'h20);
        pin_sync[5] = 1'b1;
        tick();
        rd(A_ST0, v);
        chk(v == 32'h20, "R2 rising edge pin5", v, 32'h20);
        chk(irq == 3'b001, "R11 pin5 on irq0", 32'(irq), 1);
        wr(A_ST0, 32'h20);
        tick(2);
        rd(A_ST0, v);
        chk(v == 0, "R2 held high does not re-set", v, 0);
        pin_sync[5] = 1'b0;
        tick(2);
        rd(A_ST0, v);
        chk(v == 0, "R3 falling ignored by rise enable", v, 0);
        cleanup();
    endtask

    task automatic t_fall_both();
        logic [31:0] v;
        wr(A_FALL0, 32'h4000_0000);
        pin_sync[30] = 1'b1;
        tick(2);
        rd(A_ST0, v);
        chk(v == 0, "R3 rising ignored by fall enable", v, 0);
        pin_sync[30] = 1'b0;
        tick();
        rd(A_ST0, v);
        chk(v == 32'h4000_0000, "R3 falling edge pin30", v, 32'h4000_0000);
        chk(irq == 3'b010, "R11 pin30 on irq1", 32'(irq), 2);
        wr(A_ST0, 32'h4000_0000);
        wr(A_RISE1, 32'h100);
        wr(A_FALL1, 32'h100);
        pin_sync[40] = 1'b1;
        tick();
        rd(A_ST1, v);
        chk(v == 32'h100, "R4 both edges rise pin40", v, 32'h100);
        chk(irq == 3'b010, "R11 pin40 on irq1", 32'(irq), 2);
        wr(A_ST1, 32'h100);
        pin_sync[40] = 1'b0;
        tick();
        rd(A_ST1, v);
        chk(v == 32'h100, "R4 both edges fall pin40", v, 32'h100);
        cleanup();
    endtask

    task automatic t_levels();
        logic [31:0] v;
        pin_sync[50] = 1'b1;
        wr(A_HIGH1, 32'h4_0000);
        tick();
        rd(A_ST1, v);
        chk(v == 32'h4_0000, "R5 high level pin50", v, 32'h4_0000);
        chk(irq == 3'b100, "R11 pin50 on irq2", 32'(irq), 4);
        wr(A_ST1, 32'h4_0000);
        rd(A_ST1, v);
        chk(v == 32'h4_0000, "R5 clear overridden while high", v, 32'h4_0000);
        pin_sync[50] = 1'b0;
        tick();
        wr(A_ST1, 32'h4_0000);
        rd(A_ST1, v);
        chk(v == 0, "R5 clear after level gone", v, 0);
        wr(A_LOW0, 32'h1);
        tick();
        rd(A_ST0, v);
        chk(v == 32'h1, "R6 low level pin0", v, 1);
        pin_sync[0] = 1'b1;
        tick();
        wr(A_ST0, 32'h1);
        rd(A_ST0, v);
        chk(v == 0, "R6 clear after pin0 high", v, 0);
        cleanup();
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(A_RISE0, 32'h6);
        pin_sync[2:1] = 2'b11;
        tick();
        rd(A_ST0, v);
        chk(v == 32'h6, "R8 two events", v, 6);
        wr(A_ST0, 32'h2);
        rd(A_ST0, v);
        chk(v == 32'h4, "R8 one bit cleared", v, 4);
        wr(A_ST0, 32'h0);
        rd(A_ST0, v);
        chk(v == 32'h4, "R8 zero write no effect", v, 4);
        cleanup();
    endtask

    task automatic t_disable();
        logic [31:0] v;
        wr(A_RISE0, 32'h10_0000);
        pin_sync[20] = 1'b1;
        tick();
        wr(A_RISE0, 0);
        rd(A_ST0, v);
        chk(v == 32'h10_0000, "R9 latched event persists", v, 32'h10_0000);
        wr(A_ST0, 32'h10_0000);
        pin_sync[20] = 1'b0;
        tick(2);
        pin_sync[20] = 1'b1;
        tick(2);
        rd(A_ST0, v);
        chk(v == 0, "R9 disabled pin sets nothing", v, 0);
        chk(irq == 0, "R9 no irq when disabled", 32'(irq), 0);
        cleanup();
    endtask

    task automatic t_collide();
        logic [31:0] v;
        wr(A_RISE0, 32'h8);
        pin_sync[3] = 1'b1;
        tick();
        pin_sync[3] = 1'b0;
        tick();
        pin_sync[3] = 1'b1;
        wr(A_ST0, 32'h8);
        rd(A_ST0, v);
        chk(v == 32'h8, "R10 event beats clear", v, 8);
        cleanup();
    endtask

    task automatic t_async();
        logic [31:0] v;
        wr(A_AR0, 32'h400);
        #1 pin_raw[10] = 1'b1;
        #1 pin_raw[10] = 1'b0;
        pin_raw[11] = 1'b1;
        #1 pin_raw[11] = 1'b0;
        tick(4);
        rd(A_ST0, v);
        chk(v == 32'h400, "R7 raw rising pulse pin10 only", v, 32'h400);
        wr(A_ST0, 32'hFFFF_FFFF);
        wr(A_AF1, 32'h8000);
        pin_raw[47] = 1'b1;
        tick(4);
        rd(A_ST1, v);
        chk(v == 0, "R7 raw rise ignored by fall enable", v, 0);
        #1 pin_raw[47] = 1'b0;
        tick(4);
        rd(A_ST1, v);
        chk(v == 32'h8000, "R7 raw falling pin47", v, 32'h8000);
        chk(irq == 3'b100, "R11 pin47 on irq2", 32'(irq), 4);
        cleanup();
    endtask

    initial begin
        tick(3);
        t_reset();
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_readback();
        t_rise();
        t_fall_both();
        t_levels();
        t_w1c();
        t_disable();
        t_collide();
        t_async();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule